// File: doc/BRIEF.md
# Dependence-Steered FIFO Issue Queues

This block schedules renamed instructions without an associative issue window. It keeps a few small in-order FIFOs, each meant to hold a chain of instructions that feed one another. Only the oldest entry of each FIFO can be picked for issue, so wakeup reduces to looking up a per-register ready bit for each FIFO head. The block does no tag comparison across the whole window.

Each dispatched instruction carries one destination tag and two source tags. All tags are physical (already renamed) registers. The destination must be a free register that is not a source of the same instruction. Steering uses a producer table that records, for each register, which FIFO holds the instruction that writes it. If a source's producer is the youngest entry of a FIFO with room left, the new instruction joins that FIFO. Otherwise it takes an empty FIFO, and when no FIFO is empty, dispatch stalls. A writeback port marks result tags as available. The issue side offers the head of the lowest-numbered requesting FIFO and pops it when the consumer grants.

Top module: `dep_fifo_sched`

## Requirements
- R1: After reset all FIFOs are empty, `iss_valid` is 0, `iss_req` is 0, and every register's ready bit is set. An instruction whose sources were never allocated can therefore request issue as soon as it reaches a head.
- R2: If no source has its producer at the youngest position of a non-full FIFO, the instruction goes to the empty FIFO with the smallest index. `disp_queue` reports the chosen FIFO number (0 to 3) while `disp_ready` is 1.
- R3: If the youngest entry of a non-full FIFO writes `disp_src_a`, the instruction is appended to that FIFO. Otherwise, if such an entry writes `disp_src_b`, it is appended there. Source A has priority.
- R4: If a source's producer is in a FIFO but is not its youngest entry, or has already issued, or its FIFO holds 4 entries, that source does not cause an append. The instruction falls back to the empty-FIFO rule of R2.
- R5: If neither an append nor an empty FIFO is available, `disp_ready` is 0 and a valid dispatch changes neither the FIFO contents nor the ready bits.
- R6: An accepted dispatch clears the ready bit of its destination. A writeback (`wb_valid`, `wb_tag`) sets the ready bit of that tag from the next cycle on.
- R7: Bit q of `iss_req` (bit 0 = FIFO 0) is 1 exactly when FIFO q is non-empty and both source ready bits of its head are set.
- R8: `iss_valid` offers the requesting head with the smallest FIFO index, with its FIFO number on `iss_queue` and its tags on `iss_dst`, `iss_src_a` and `iss_src_b`. `iss_valid` together with `iss_grant` removes that head at the clock edge.
- R9: An entry behind a head never requests or issues before that head, even when its own sources are ready.
- R10: If a dispatch and a writeback name the same register in one cycle, the register ends that cycle not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_dst | input | 5 | Destination register tag |
| disp_src_a | input | 5 | First source register tag |
| disp_src_b | input | 5 | Second source register tag |
| disp_queue | output | 2 | FIFO the instruction would enter |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | 5 | Register whose value is now available |
| iss_req | output | 4 | Per-FIFO head-ready flags |
| iss_valid | output | 1 | An issue candidate is offered |
| iss_queue | output | 2 | FIFO of the offered head |
| iss_dst | output | 5 | Destination tag of the offered head |
| iss_src_a | output | 5 | First source tag of the offered head |
| iss_src_b | output | 5 | Second source tag of the offered head |
| iss_grant | input | 1 | Consumer takes the offered head |

## Verification
A stale ready bit shows up on `iss_req` on the cycle after the offending dispatch or writeback. Either a head stays silent after its operand was written back, or it requests while an operand is pending. A corrupted producer entry or tail tag shows on `disp_queue` at the very next dispatch that names the affected register. A FIFO pointer error shows on `iss_dst` as soon as the affected FIFO pops. The scenario walks one fixed program through every steering path, the stall, the per-head wakeup and the pop order, and checks each of these ports cycle by cycle.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int DSQ_NQ    = 4;
  localparam int DSQ_DEPTH = 4;
  localparam int DSQ_NREG  = 32;

  // index width of at least one bit
  function automatic int dsq_idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dsq_fifo.sv
module dsq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 15,
  parameter int KW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [KW-1:0] tail_key,
  output logic          empty,
  output logic          full
);
  localparam int AW = dsq_pkg::dsq_idx_w(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, tp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_comb begin
    tp       = (wp == '0) ? AW'(DEPTH - 1) : wp - 1'b1;
    head     = mem[rp];
    tail_key = mem[tp][W-1 -: KW];
    empty    = (cnt == '0);
    full     = (cnt == CW'(DEPTH));
  end
endmodule

// File: rtl/dsq_regtab.sv
module dsq_regtab #(
  parameter int NREG = 32,
  parameter int NQ   = 4,
  localparam int RW  = dsq_pkg::dsq_idx_w(NREG),
  localparam int QW  = dsq_pkg::dsq_idx_w(NQ)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alloc_en,
  input  logic [RW-1:0]             alloc_reg,
  input  logic [QW-1:0]             alloc_q,
  input  logic                      wb_en,
  input  logic [RW-1:0]             wb_reg,
  input  logic                      free_en,
  input  logic [RW-1:0]             free_reg,
  input  logic [QW-1:0]             free_q,
  output logic [NREG-1:0]           rdy_vec,
  output logic [NREG-1:0]           pvld_vec,
  output logic [NREG-1:0][QW-1:0]   pq_vec
);
  // ready bits and producer-valid bits; later writes win
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_vec  <= '1;
      pvld_vec <= '0;
    end else begin
      if (wb_en)    rdy_vec[wb_reg]    <= 1'b1;
      if (alloc_en) rdy_vec[alloc_reg] <= 1'b0;
      if (free_en && pvld_vec[free_reg] && (pq_vec[free_reg] == free_q))
        pvld_vec[free_reg] <= 1'b0;
      if (alloc_en) pvld_vec[alloc_reg] <= 1'b1;
    end
  end

  // producer FIFO numbers, qualified by pvld_vec
  always_ff @(posedge clk) begin
    if (alloc_en) pq_vec[alloc_reg] <= alloc_q;
  end
endmodule

// File: rtl/dsq_steer.sv
module dsq_steer #(
  parameter int NQ = 4,
  parameter int RW = 5,
  parameter int QW = 2
) (
  input  logic [RW-1:0]          src_a,
  input  logic [RW-1:0]          src_b,
  input  logic                   pa_vld,
  input  logic [QW-1:0]          pa_q,
  input  logic                   pb_vld,
  input  logic [QW-1:0]          pb_q,
  input  logic [NQ-1:0][RW-1:0]  tail_dst,
  input  logic [NQ-1:0]          q_empty,
  input  logic [NQ-1:0]          q_full,
  output logic                   ok,
  output logic [QW-1:0]          qsel
);
  logic          a_hit, b_hit, any_empty;
  logic [QW-1:0] low_empty;

  always_comb begin
    a_hit = pa_vld && !q_empty[pa_q] && !q_full[pa_q] && (tail_dst[pa_q] == src_a);
    b_hit = pb_vld && !q_empty[pb_q] && !q_full[pb_q] && (tail_dst[pb_q] == src_b);

    any_empty = 1'b0;
    low_empty = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (q_empty[i]) begin
        any_empty = 1'b1;
        low_empty = QW'(i);
      end
    end

    if (a_hit)      qsel = pa_q;
    else if (b_hit) qsel = pb_q;
    else            qsel = low_empty;
    ok = a_hit || b_hit || any_empty;
  end
endmodule

// File: rtl/dsq_pick.sv
module dsq_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          vld,
  output logic [IW-1:0] idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        vld = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dep_fifo_sched.sv
module dep_fifo_sched #(
  parameter int  NQ    = dsq_pkg::DSQ_NQ,
  parameter int  DEPTH = dsq_pkg::DSQ_DEPTH,
  parameter int  NREG  = dsq_pkg::DSQ_NREG,
  localparam int RW    = dsq_pkg::dsq_idx_w(NREG),
  localparam int QW    = dsq_pkg::dsq_idx_w(NQ)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          disp_valid,
  output logic          disp_ready,
  input  logic [RW-1:0] disp_dst,
  input  logic [RW-1:0] disp_src_a,
  input  logic [RW-1:0] disp_src_b,
  output logic [QW-1:0] disp_queue,
  input  logic          wb_valid,
  input  logic [RW-1:0] wb_tag,
  output logic [NQ-1:0] iss_req,
  output logic          iss_valid,
  output logic [QW-1:0] iss_queue,
  output logic [RW-1:0] iss_dst,
  output logic [RW-1:0] iss_src_a,
  output logic [RW-1:0] iss_src_b,
  input  logic          iss_grant
);
  localparam int EW = 3 * RW;

  logic [NREG-1:0]          rdy_vec, pvld_vec;
  logic [NREG-1:0][QW-1:0]  pq_vec;
  logic [NQ-1:0]            q_empty, q_full, q_push, q_pop;
  logic [NQ-1:0][EW-1:0]    head_e;
  logic [NQ-1:0][RW-1:0]    tail_dst, head_dst, head_a, head_b;
  logic                     steer_ok, disp_fire, iss_fire, gnt_vld;
  logic [QW-1:0]            steer_q, gnt_q;

  assign disp_fire = disp_valid && steer_ok;
  assign iss_fire  = gnt_vld && iss_grant;

  dsq_regtab #(.NREG(NREG), .NQ(NQ)) regtab_i (
    .clk      (clk),
    .rst      (rst),
    .alloc_en (disp_fire),
    .alloc_reg(disp_dst),
    .alloc_q  (steer_q),
    .wb_en    (wb_valid),
    .wb_reg   (wb_tag),
    .free_en  (iss_fire),
    .free_reg (head_dst[gnt_q]),
    .free_q   (gnt_q),
    .rdy_vec  (rdy_vec),
    .pvld_vec (pvld_vec),
    .pq_vec   (pq_vec)
  );

  dsq_steer #(.NQ(NQ), .RW(RW), .QW(QW)) steer_i (
    .src_a   (disp_src_a),
    .src_b   (disp_src_b),
    .pa_vld  (pvld_vec[disp_src_a]),
    .pa_q    (pq_vec[disp_src_a]),
    .pb_vld  (pvld_vec[disp_src_b]),
    .pb_q    (pq_vec[disp_src_b]),
    .tail_dst(tail_dst),
    .q_empty (q_empty),
    .q_full  (q_full),
    .ok      (steer_ok),
    .qsel    (steer_q)
  );

  // entry layout: {dst, src_a, src_b}; dst on top for the tail key
  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign q_push[q] = disp_fire && (steer_q == QW'(q));
    assign q_pop[q]  = iss_fire && (gnt_q == QW'(q));

    dsq_fifo #(.DEPTH(DEPTH), .W(EW), .KW(RW)) fifo_i (
      .clk     (clk),
      .rst     (rst),
      .push    (q_push[q]),
      .pop     (q_pop[q]),
      .wdata   ({disp_dst, disp_src_a, disp_src_b}),
      .head    (head_e[q]),
      .tail_key(tail_dst[q]),
      .empty   (q_empty[q]),
      .full    (q_full[q])
    );

    assign head_dst[q] = head_e[q][EW-1 -: RW];
    assign head_a[q]   = head_e[q][2*RW-1 -: RW];
    assign head_b[q]   = head_e[q][RW-1:0];
    assign iss_req[q]  = !q_empty[q] && rdy_vec[head_a[q]] && rdy_vec[head_b[q]];
  end

  dsq_pick #(.N(NQ), .IW(QW)) pick_i (
    .req(iss_req),
    .vld(gnt_vld),
    .idx(gnt_q)
  );

  assign disp_ready = steer_ok;
  assign disp_queue = steer_q;
  assign iss_valid  = gnt_vld;
  assign iss_queue  = gnt_q;
  assign iss_dst    = head_dst[gnt_q];
  assign iss_src_a  = head_a[gnt_q];
  assign iss_src_b  = head_b[gnt_q];
endmodule

// File: rtl/dep_fifo_sched_chk.sv
module dep_fifo_sched_chk #(
  parameter int  NQ   = 4,
  parameter int  NREG = 32,
  localparam int RW   = dsq_pkg::dsq_idx_w(NREG),
  localparam int QW   = dsq_pkg::dsq_idx_w(NQ)
) (
  input logic            clk,
  input logic            rst,
  input logic            disp_valid,
  input logic            disp_ready,
  input logic [RW-1:0]   disp_dst,
  input logic            wb_valid,
  input logic [RW-1:0]   wb_tag,
  input logic [NQ-1:0]   iss_req,
  input logic            iss_valid,
  input logic [QW-1:0]   iss_queue,
  input logic [RW-1:0]   iss_src_a,
  input logic [RW-1:0]   iss_src_b,
  input logic [NREG-1:0] rdy_vec,
  input logic [NQ-1:0]   q_empty
);
  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> iss_req[iss_queue]); // R8

  for (genvar i = 0; i < NQ; i++) begin : g_low
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && (int'(iss_queue) > i)) |-> !iss_req[i]); // R8
  end

  AST_ISSUE_OPERANDS_READY: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (rdy_vec[iss_src_a] && rdy_vec[iss_src_b])); // R7

  AST_ALLOC_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready) |=> !rdy_vec[$past(disp_dst)]); // R6

  AST_WB_SETS_READY: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !(disp_valid && disp_ready && (disp_dst == wb_tag)))
      |=> rdy_vec[$past(wb_tag)]); // R6

  AST_STALL_NO_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !disp_ready |-> (q_empty == '0)); // R5
endmodule

bind dep_fifo_sched dep_fifo_sched_chk #(.NQ(NQ), .NREG(NREG)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .disp_valid(disp_valid),
  .disp_ready(disp_ready),
  .disp_dst  (disp_dst),
  .wb_valid  (wb_valid),
  .wb_tag    (wb_tag),
  .iss_req   (iss_req),
  .iss_valid (iss_valid),
  .iss_queue (iss_queue),
  .iss_src_a (iss_src_a),
  .iss_src_b (iss_src_b),
  .rdy_vec   (rdy_vec),
  .q_empty   (q_empty)
);

// File: tb/dep_fifo_sched_tb_top.sv
`timescale 1ns/1ps
module dep_fifo_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       disp_valid = 1'b0, wb_valid = 1'b0, iss_grant = 1'b0;
  logic [4:0] disp_dst = '0, disp_src_a = '0, disp_src_b = '0, wb_tag = '0;
  logic       disp_ready, iss_valid;
  logic [1:0] disp_queue, iss_queue;
  logic [3:0] iss_req;
  logic [4:0] iss_dst, iss_src_a, iss_src_b;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dep_fifo_sched dut_i (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_dst(disp_dst), .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
    .disp_queue(disp_queue),
    .wb_valid(wb_valid), .wb_tag(wb_tag),
    .iss_req(iss_req), .iss_valid(iss_valid), .iss_queue(iss_queue),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_grant(iss_grant)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // drive one cycle of inputs at the falling edge; outputs settle 1 ns later
  task automatic drive(input bit dv, input int dst, input int a, input int b,
                       input bit wv, input int wt, input bit g);
    @(negedge clk);
    disp_valid = dv; disp_dst = 5'(dst); disp_src_a = 5'(a); disp_src_b = 5'(b);
    wb_valid = wv; wb_tag = 5'(wt); iss_grant = g;
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic disp(input int dst, input int a, input int b, input int q, input string rq);
    drive(1, dst, a, b, 0, 0, 0);
    chk({rq, " disp_ready"}, int'(disp_ready), 1);
    chk({rq, " disp_queue"}, int'(disp_queue), q);
  endtask

  task automatic wb(input int t);
    drive(0, 0, 0, 0, 1, t, 0);
  endtask

  task automatic grant();
    drive(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic see(input int req, input int q, input int dst, input string rq);
    chk({rq, " iss_req"}, int'(iss_req), req);
    chk({rq, " iss_valid"}, int'(iss_valid), (req != 0) ? 1 : 0);
    if (req != 0) begin
      chk({rq, " iss_queue"}, int'(iss_queue), q);
      chk({rq, " iss_dst"}, int'(iss_dst), dst);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: empty after reset
    see(0, 0, 0, "R1 reset");
    chk("R1 disp_ready", int'(disp_ready), 1);

    // R2: first instruction into FIFO 0; reset ready bits let it request (R1, R7)
    disp(5, 1, 2, 0, "R2 first");
    idle();
    see(1, 0, 5, "R1 R7 head ready");
    chk("R8 iss_src_a", int'(iss_src_a), 1);
    chk("R8 iss_src_b", int'(iss_src_b), 2);

    disp(6, 5, 3, 0, "R3 src_a append");
    disp(7, 9, 6, 0, "R3 src_b append");
    disp(8, 5, 4, 1, "R4 producer not youngest");
    idle();
    see(1, 0, 5, "R6 R7 q1 waits on r5");
    disp(10, 7, 8, 0, "R3 src_a priority");
    disp(11, 10, 1, 2, "R4 full fifo");
    disp(12, 1, 2, 3, "R2 lowest empty");
    idle();
    see(9, 0, 5, "R7 two heads");

    // R5: stall with no append and no empty FIFO
    drive(1, 13, 3, 4, 0, 0, 0);
    chk("R5 disp_ready low", int'(disp_ready), 0);
    idle();
    see(9, 0, 5, "R5 no change");

    // R8: pop q0 head, next requester is q3
    grant();
    idle();
    see(8, 3, 12, "R8 lowest after pop");

    wb(5);
    idle();
    see(11, 0, 6, "R6 writeback wakes");
    grant();
    idle();
    see(10, 1, 8, "R8 next lowest");
    chk("R8 iss_src_a q1", int'(iss_src_a), 5);
    chk("R8 iss_src_b q1", int'(iss_src_b), 4);
    grant();
    idle();
    see(8, 3, 12, "R8 q3 head");
    grant();
    idle();
    see(0, 0, 0, "R7 none ready");

    // R9: follower ready while head blocked
    disp(21, 6, 1, 1, "R4 producer issued");
    disp(22, 1, 21, 1, "R3 src_b append");
    wb(21);
    idle();
    see(0, 0, 0, "R9 follower held");
    wb(8);
    wb(6);
    idle();
    see(3, 0, 7, "R9 head wakes");
    grant();
    idle();
    see(2, 1, 21, "R9 q1 head");
    grant();
    idle();
    see(2, 1, 22, "R9 follower after head");
    grant();
    idle();
    see(0, 0, 0, "R9 drained");

    // R10: dispatch and writeback of r7 in the same cycle
    drive(1, 7, 1, 2, 1, 7, 0);
    chk("R10 disp_queue", int'(disp_queue), 1);
    idle();
    see(2, 1, 7, "R10 clear wins");
    wb(7);
    idle();
    see(3, 0, 10, "R6 late writeback");

    finish_run();
  end
endmodule